// File: doc/BRIEF.md
# Keyed-Arm Watchdog Timer

This block is a watchdog peripheral that counts upward from a programmed start value on a slow periodic tick. A clock-enable style input marks each tick of a 32 kHz timebase, and an optional prescaler can thin those ticks by a power of two. When the count rolls over past all ones while the watchdog is armed, the block raises a one-cycle reset request and restarts from the start value. Because the count runs upward, a larger start value gives a shorter timeout.

Software talks to the block through a flat register bus with a write strobe, a byte address, write data and combinational read data. Arming and disarming need a two-word key sequence written to one register. The watchdog is refreshed by writing a trigger register with a value that differs from the one it already holds. The bus is assumed to be already in the block's clock domain. The asynchronous active-low reset is released through a two-stage synchroniser.

Top module: `wdt_keyed_timer`

## Requirements
- R1: The watchdog becomes armed only after two consecutive bus writes to offset 0x48, the first carrying the full 32-bit word 0x0000BBBB and the second 0x00004444. A word that matches only in its low 16 bits does not count.
- R2: The watchdog becomes disarmed only after two consecutive writes to offset 0x48 of 0x0000AAAA and then 0x00005555. While it is disarmed, the counter holds its value.
- R3: A partial key sequence is thrown away when the next write to 0x48 is not the matching second word, or when any write to another offset comes in between. The armed state then stays as it was.
- R4: A write to the trigger register (0x30) with a value different from the one it holds loads the counter from the start register (0x2C) at that clock edge. A write of the same value leaves the counter alone.
- R5: While armed, the counter goes up by one on each prescaled tick.
- R6: When the counter is at 0xFFFFFFFF and an armed tick arrives, the counter reloads from the start register and reset_req is high for exactly the following cycle. Back-to-back pulses occur when the start value is itself all ones.
- R7: In the control register (0x24), bit 5 enables the prescaler and bits 4:2 hold a ratio N. When the prescaler is enabled, one step happens for every 2^N input ticks. When it is disabled, every tick is a step. Any control write restarts the division phase.
- R8: After reset the watchdog is armed, the start value and the counter are both 0xFFFB0000, the control register reads zero and reset_req is low.
- R9: Reads return the revision code in bits 7:0 at 0x00, the control register at 0x24 with only bits 5:2 stored, the counter at 0x28, the start value at 0x2C, the trigger value at 0x30, zero at 0x34, and the last key word at 0x48. Any other offset reads zero.
- R10: A write to 0x28 sets the counter directly and takes precedence over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle pulse per timebase tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| reset_req | output | 1 | One-cycle reset request on rollover |

## Verification
The hardest state to reach from the ports is the rollover. From the reset start value it would take hundreds of thousands of ticks. The stimulus gets there by writing the counter directly to a few counts below all ones and by programming start values close to the top, with a tick on every cycle. A start value of all ones is then used to force back-to-back pulses. The broken key sequences are driven while the watchdog is disarmed, so any wrong arming shows up as the counter starting to move.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] OFS_REV  = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h24;
  localparam logic [7:0] OFS_CNT  = 8'h28;
  localparam logic [7:0] OFS_LOAD = 8'h2C;
  localparam logic [7:0] OFS_TRIG = 8'h30;
  localparam logic [7:0] OFS_PEND = 8'h34;
  localparam logic [7:0] OFS_KEY  = 8'h48;

  localparam logic [15:0] KEY_ARM_FIRST  = 16'hBBBB;
  localparam logic [15:0] KEY_ARM_SECOND = 16'h4444;
  localparam logic [15:0] KEY_OFF_FIRST  = 16'hAAAA;
  localparam logic [15:0] KEY_OFF_SECOND = 16'h5555;

  localparam int CTRL_PRE_EN_BIT = 5;
  localparam int CTRL_RATIO_LSB  = 2;
  localparam int RATIO_W         = 3;

  typedef enum logic [1:0] {
    KS_IDLE     = 2'd0,
    KS_ARM_HALF = 2'd1,
    KS_OFF_HALF = 2'd2
  } key_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  REV_CODE = 8'h31,
  parameter logic [31:0] RST_LOAD = 32'hFFFB0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  cnt_val,
  output logic               pre_en,
  output logic [RATIO_W-1:0] ratio,
  output logic [DATA_W-1:0]  load_val,
  output logic               reload,
  output logic               cnt_wr,
  output logic               ctrl_wr,
  output logic               key_wr,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam int CTRL_W = RATIO_W + 1;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_q, load_d;
  logic [DATA_W-1:0] trig_q, trig_d;
  logic [DATA_W-1:0] key_q, key_d;
  logic              load_wr, trig_wr;

  assign ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
  assign cnt_wr  = bus_we && (bus_addr == OFS_CNT);
  assign load_wr = bus_we && (bus_addr == OFS_LOAD);
  assign trig_wr = bus_we && (bus_addr == OFS_TRIG);
  assign key_wr  = bus_we && (bus_addr == OFS_KEY);

  // Refresh only on a changed trigger word
  assign reload  = trig_wr && (bus_wdata != trig_q);

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    trig_d = trig_q;
    key_d  = key_q;
    if (ctrl_wr) ctrl_d = {bus_wdata[CTRL_PRE_EN_BIT],
                           bus_wdata[CTRL_RATIO_LSB +: RATIO_W]};
    if (load_wr) load_d = bus_wdata;
    if (trig_wr) trig_d = bus_wdata;
    if (key_wr)  key_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= RST_LOAD[DATA_W-1:0];
      trig_q <= '0;
      key_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      trig_q <= trig_d;
      key_q  <= key_d;
    end
  end

  assign pre_en   = ctrl_q[CTRL_W-1];
  assign ratio    = ctrl_q[RATIO_W-1:0];
  assign load_val = load_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_REV:  bus_rdata[7:0] = REV_CODE;
      OFS_CTRL: begin
        bus_rdata[CTRL_PRE_EN_BIT]              = ctrl_q[CTRL_W-1];
        bus_rdata[CTRL_RATIO_LSB +: RATIO_W]    = ctrl_q[RATIO_W-1:0];
      end
      OFS_CNT:  bus_rdata = cnt_val;
      OFS_LOAD: bus_rdata = load_q;
      OFS_TRIG: bus_rdata = trig_q;
      OFS_PEND: bus_rdata = '0;
      OFS_KEY:  bus_rdata = key_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R4: an equal trigger write never refreshes
  p_same_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && $past(trig_wr) && bus_wdata == $past(bus_wdata)) |-> !reload);
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              armed
);
  localparam logic [DATA_W-1:0] W_ARM_A = DATA_W'(KEY_ARM_FIRST);
  localparam logic [DATA_W-1:0] W_ARM_B = DATA_W'(KEY_ARM_SECOND);
  localparam logic [DATA_W-1:0] W_OFF_A = DATA_W'(KEY_OFF_FIRST);
  localparam logic [DATA_W-1:0] W_OFF_B = DATA_W'(KEY_OFF_SECOND);

  key_state_e state_q, state_d;
  logic       armed_q, armed_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    if (key_wr) begin
      unique case (state_q)
        KS_IDLE: begin
          if (bus_wdata == W_ARM_A)      state_d = KS_ARM_HALF;
          else if (bus_wdata == W_OFF_A) state_d = KS_OFF_HALF;
          else                           state_d = KS_IDLE;
        end
        KS_ARM_HALF: begin
          if (bus_wdata == W_ARM_B) armed_d = 1'b1;
          state_d = KS_IDLE;
        end
        KS_OFF_HALF: begin
          if (bus_wdata == W_OFF_B) armed_d = 1'b0;
          state_d = KS_IDLE;
        end
        default: state_d = KS_IDLE;
      endcase
    end else if (bus_we) begin
      state_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_IDLE;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign armed = armed_q;

  // R1: arming follows the closing arm word
  p_arm_by_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(key_wr && bus_wdata == W_ARM_B));
  // R2: disarming follows the closing disarm word
  p_off_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed_q) |-> $past(key_wr && bus_wdata == W_OFF_B));
  // R3: a foreign write leaves no half sequence behind
  p_foreign_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !key_wr) |=> (state_q == KS_IDLE));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_in,
  input  logic               pre_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               restart,
  output logic               tick_out
);
  localparam int DIV_W = (1 << RATIO_W) - 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] span_last;
  logic             at_last;

  assign span_last = (DIV_W'(1) << ratio) - DIV_W'(1);
  assign at_last   = (div_q == span_last);
  assign tick_out  = tick_in && (!pre_en || at_last);

  always_comb begin
    div_d = div_q;
    if (restart)               div_d = '0;
    else if (pre_en && tick_in) div_d = at_last ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R7: with a ratio of one or more, divided ticks never come back to back
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && ratio != '0 && tick_out && !restart) |=> !tick_out);
  // R7: the divided tick only ever accompanies an input tick
  p_tick_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> tick_in);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int          CNT_W    = 32,
  parameter logic [31:0] RST_LOAD = 32'hFFFB0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             step,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             advance;

  assign advance = armed && step;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (reload) begin
      cnt_d = load_val;
    end else if (cnt_wr) begin
      cnt_d = wr_val;
    end else if (advance) begin
      if (cnt_q == CNT_TOP) begin
        cnt_d = load_val;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RST_LOAD[CNT_W-1:0];
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = req_q;

  // R4: a refresh lands the start value
  p_reload_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(load_val)));
  // R6: a request only follows an armed rollover
  p_req_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> ($past(cnt_q) == CNT_TOP && $past(armed) && $past(step)));
  // R2: disarmed and untouched means frozen
  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !reload && !cnt_wr) |=> $stable(cnt_q));
  // R5: an armed plain step below the top adds one
  p_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step && !reload && !cnt_wr && cnt_q != CNT_TOP)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
  import wdt_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [7:0]  REV_CODE = 8'h31,
  parameter logic [31:0] RST_LOAD = 32'hFFFB0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  logic               pre_en, reload, cnt_wr, ctrl_wr, key_wr, armed, step;
  logic [RATIO_W-1:0] ratio;
  logic [DATA_W-1:0]  load_val, cnt_val;

  wdt_regs #(
    .DATA_W   (DATA_W),
    .REV_CODE (REV_CODE),
    .RST_LOAD (RST_LOAD)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt_val),
    .pre_en    (pre_en),
    .ratio     (ratio),
    .load_val  (load_val),
    .reload    (reload),
    .cnt_wr    (cnt_wr),
    .ctrl_wr   (ctrl_wr),
    .key_wr    (key_wr),
    .bus_rdata (bus_rdata)
  );

  wdt_key_seq #(.DATA_W(DATA_W)) u_keys (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .bus_we    (bus_we),
    .key_wr    (key_wr),
    .bus_wdata (bus_wdata),
    .armed     (armed)
  );

  wdt_prescaler #(.RATIO_W(RATIO_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .tick_in  (tick_32k),
    .pre_en   (pre_en),
    .ratio    (ratio),
    .restart  (ctrl_wr),
    .tick_out (step)
  );

  wdt_counter #(
    .CNT_W    (DATA_W),
    .RST_LOAD (RST_LOAD)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .armed    (armed),
    .step     (step),
    .reload   (reload),
    .load_val (load_val),
    .cnt_wr   (cnt_wr),
    .wr_val   (bus_wdata),
    .cnt      (cnt_val),
    .rst_req  (reset_req)
  );
endmodule

// File: tb/wdt_keyed_timer_bench.sv
module wdt_keyed_timer_bench;
  localparam int CLK_P = 10;
  localparam logic [7:0] REV = 8'h31;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_32k = 1'b0;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        reset_req;

  always #(CLK_P/2) clk = ~clk;

  wdt_keyed_timer u_wdt_keyed_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_32k  (tick_32k),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .reset_req (reset_req)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    pulses = 0;
  int    tick_gap = 0;
  int    tick_ph = 0;
  string phase = "R8";
  bit    done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // tick source
  always @(negedge clk) begin
    tick_32k = (tick_gap != 0) && (tick_ph % (tick_gap == 0 ? 1 : tick_gap) == 0);
    tick_ph++;
  end

  // behavioural reference model
  bit [31:0] m_cnt, m_load, m_trig, m_key;
  bit [3:0]  m_ctrl;
  bit        m_en, m_req;
  int        m_seq, m_div, rel;
  bit [7:0]  s_addr;

  function automatic bit [31:0] exp_read(input bit [7:0] a);
    case (a)
      8'h00: return {24'h0, REV};
      8'h24: return {26'h0, m_ctrl, 2'b00};
      8'h28: return m_cnt;
      8'h2C: return m_load;
      8'h30: return m_trig;
      8'h48: return m_key;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit        pe, stp, we;
    int        span, ndiv;
    bit [7:0]  a;
    bit [31:0] d;
    we = bus_we; a = bus_addr; d = bus_wdata;
    s_addr = bus_addr;
    if (!rst_n) begin
      rel = 0;
      m_cnt = 32'hFFFB0000; m_load = 32'hFFFB0000; m_trig = 0; m_key = 0;
      m_ctrl = 0; m_en = 1; m_req = 0; m_seq = 0; m_div = 0;
    end else if (rel < 2) begin
      rel++;
    end else begin
      pe   = m_ctrl[3];
      span = 1 << m_ctrl[2:0];
      stp  = tick_32k && (!pe || m_div == span - 1);
      ndiv = m_div;
      if (we && a == 8'h24) ndiv = 0;
      else if (pe && tick_32k) ndiv = (m_div == span - 1) ? 0 : m_div + 1;
      m_div = ndiv;
      m_req = 0;
      if (we && a == 8'h30 && d != m_trig) m_cnt = m_load;
      else if (we && a == 8'h28) m_cnt = d;
      else if (m_en && stp) begin
        if (m_cnt == 32'hFFFFFFFF) begin m_cnt = m_load; m_req = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (we) begin
        if (a == 8'h48) begin
          case (m_seq)
            0: m_seq = (d == 32'hBBBB) ? 1 : (d == 32'hAAAA) ? 2 : 0;
            1: begin if (d == 32'h4444) m_en = 1; m_seq = 0; end
            default: begin if (d == 32'h5555) m_en = 0; m_seq = 0; end
          endcase
        end else m_seq = 0;
        if (a == 8'h24) m_ctrl = {d[5], d[4:2]};
        if (a == 8'h2C) m_load = d;
        if (a == 8'h30) m_trig = d;
        if (a == 8'h48) m_key = d;
      end
    end
    #(CLK_P/4);
    chk({phase, " rdata"}, bus_rdata, exp_read(s_addr));
    chk({phase, " reset_req"}, {31'h0, reset_req}, {31'h0, m_req});
    if (reset_req === 1'b1) pulses++;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 8'h28; bus_wdata = 0;
  endtask

  task automatic rd_val(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #(CLK_P/4 + 1);
    v = bus_rdata;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd_val(a, v);
    chk(tag, v, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    logic [31:0] c0, c1;
    int p0;
    rst_n = 0; bus_we = 0; bus_addr = 8'h28; bus_wdata = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    // R8 reset state
    rd_check(8'h28, 32'hFFFB0000, "R8 counter");
    rd_check(8'h2C, 32'hFFFB0000, "R8 load");
    rd_check(8'h24, 32'h0, "R8 control");
    chk("R8 reset_req", {31'h0, reset_req}, 32'h0);
    // R9 read map
    phase = "R9";
    rd_check(8'h00, {24'h0, REV}, "R9 revision");
    rd_check(8'h34, 32'h0, "R9 pending");
    rd_check(8'h40, 32'h0, "R9 unmapped");
    bus_wr(8'h24, 32'hFFFFFFFF);
    rd_check(8'h24, 32'h0000003C, "R9 control bits");
    bus_wr(8'h24, 32'h0);
    // R5 counting while armed
    phase = "R5";
    tick_gap = 3;
    rd_val(8'h28, c0);
    idle(30);
    rd_val(8'h28, c1);
    chk("R5 counter moved", {31'h0, c1 != c0}, 32'h1);
    // R2 disarm
    phase = "R2";
    bus_wr(8'h48, 32'hAAAA);
    bus_wr(8'h48, 32'h5555);
    idle(2);
    rd_val(8'h28, c0);
    idle(20);
    rd_check(8'h28, c0, "R2 frozen while disarmed");
    // R3 broken sequences
    phase = "R3";
    bus_wr(8'h48, 32'hBBBB);
    bus_wr(8'h48, 32'h1234);
    bus_wr(8'h48, 32'h4444);
    idle(10);
    rd_check(8'h28, c0, "R3 mismatched second word");
    bus_wr(8'h48, 32'hBBBB);
    bus_wr(8'h2C, 32'hFFFB0000);
    bus_wr(8'h48, 32'h4444);
    idle(10);
    rd_check(8'h28, c0, "R3 foreign write between");
    // R1 full-width match and arming
    phase = "R1";
    bus_wr(8'h48, 32'hBBBB);
    bus_wr(8'h48, 32'h00014444);
    idle(10);
    rd_check(8'h28, c0, "R1 upper bits must be zero");
    bus_wr(8'h48, 32'hBBBB);
    bus_wr(8'h48, 32'h4444);
    idle(10);
    rd_val(8'h28, c1);
    chk("R1 armed counter moves", {31'h0, c1 != c0}, 32'h1);
    // R7 prescaler
    phase = "R7";
    tick_gap = 1;
    bus_wr(8'h24, 32'h28);
    idle(40);
    bus_wr(8'h24, 32'h3C);
    idle(300);
    bus_wr(8'h24, 32'h20);
    idle(10);
    bus_wr(8'h24, 32'h0);
    idle(5);
    // R4 refresh
    phase = "R4";
    tick_gap = 0;
    bus_wr(8'h2C, 32'hFFFFFF00);
    bus_wr(8'h30, 32'h5);
    rd_check(8'h28, 32'hFFFFFF00, "R4 reload on new word");
    phase = "R10";
    bus_wr(8'h28, 32'h10);
    rd_check(8'h28, 32'h10, "R10 direct write");
    phase = "R4";
    bus_wr(8'h30, 32'h5);
    rd_check(8'h28, 32'h10, "R4 same word ignored");
    bus_wr(8'h30, 32'h6);
    rd_check(8'h28, 32'hFFFFFF00, "R4 reload again");
    // R10 write beats a tick
    phase = "R10";
    tick_gap = 1;
    bus_wr(8'h28, 32'h100);
    tick_gap = 0;
    idle(2);
    // R6 rollover
    phase = "R6";
    bus_wr(8'h2C, 32'hFFFFFFF0);
    bus_wr(8'h28, 32'hFFFFFFFA);
    p0 = pulses;
    tick_gap = 1;
    idle(30);
    chk("R6 rollover pulses seen", {31'h0, pulses > p0}, 32'h1);
    bus_wr(8'h2C, 32'hFFFFFFFF);
    bus_wr(8'h30, 32'h7);
    idle(6);
    tick_gap = 0;
    idle(2);
    // R2 no rollover while disarmed
    phase = "R2";
    bus_wr(8'h48, 32'hAAAA);
    bus_wr(8'h48, 32'h5555);
    bus_wr(8'h28, 32'hFFFFFFFF);
    p0 = pulses;
    tick_gap = 1;
    idle(10);
    chk("R2 no request while disarmed", pulses - p0, 0);
    rd_check(8'h28, 32'hFFFFFFFF, "R2 held at top");
    tick_gap = 0;
    idle(3);
    finish_run();
  end
endmodule